// File: doc/BRIEF.md
# Iterative AES Block Decryptor

This block turns one 128-bit AES ciphertext block back into plaintext. It runs one inverse round per clock. The round keys are not expanded inside the block. They come from a schedule that was computed earlier and is held outside, for example in a synchronous RAM that the encryptor also uses. The block drives a round-key index. The word for that index must appear on the round-key input one clock later, which is exactly the timing of a synchronous RAM read. Because decryption walks the schedule backwards, the index counts down.

One clock edge with `start` high and the block idle does three things: it latches the ciphertext, it applies the initial AddRoundKey with key Nr, and it captures the key size. Each following edge performs one inverse round in this order: InvShiftRows, InvSubBytes, AddRoundKey, then InvMixColumns. The final round leaves out InvMixColumns. The plaintext register loads on the final edge and `pt_ready` pulses in the cycle after it. A new block may start in that same cycle, so a stream runs at one block per Nr+1 clocks.

Top module: `aes_block_decrypt`

## Requirements
- R1: While reset is high, and right after it is released, `pt_ready` is 0, `pt_out` is 0, no operation is pending, and `rk_idx` shows the idle value from R2.
- R2: `key_size` selects the round count Nr: 2'b00 gives 10, 2'b01 gives 12, 2'b10 gives 14, and 2'b11 gives 10. While idle with `start` low, `rk_idx` equals Nr for the current `key_size`.
- R3: `start` is accepted on an edge where the block is idle. In that cycle `rk_idx` shows Nr-1. On the accepting edge, `ct_in` is XORed with the `rk_word` present at that edge, which is round key Nr.
- R4: `pt_ready` is high for exactly one cycle. That cycle begins Nr edges after the accepting edge, so the latency is Nr+1 clocks counting the start cycle. `pt_out` then holds the AES decryption of the accepted ciphertext, with the last round omitting InvMixColumns.
- R5: After the accepting edge, `rk_idx` shows Nr-2 and drops by one each cycle down to 0. In the final round cycle it shows Nr for the current `key_size`.
- R6: `start` has no effect while a block is in progress, including its final round cycle.
- R7: A `start` in the cycle where `pt_ready` is high is accepted. Back-to-back blocks complete every Nr+1 clocks.
- R8: `pt_out` changes only on the edge that raises `pt_ready` and holds its value between completions.
- R9: `key_size` and `ct_in` are captured on the accepting edge. Changing them later does not alter the round count, the key order or the result of the block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decryption when idle |
| key_size | input | 2 | Key size select (00:128, 01:192, 10:256, 11:128) |
| ct_in | input | 128 | Ciphertext block, byte 0 in bits 127:120 |
| rk_word | input | 128 | Round key for the index shown one clock earlier |
| rk_idx | output | 4 | Round-key index requested for the next cycle |
| pt_out | output | 128 | Plaintext of the last completed block |
| pt_ready | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the timing on every cycle:
- the exact position of the `pt_ready` pulse relative to the accepting edge;
- the countdown of `rk_idx` and its idle and start-cycle values;
- `pt_out` holding still between completions.

They do not check the data. Only the bench scenarios can show that:
- the plaintext is correct for every key size, including the 2'b11 alias (known-answer blocks and random round trips through an independent encryptor);
- starts and input changes during a block are ignored;
- back-to-back streaming reaches full rate.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

    localparam int BLK_W  = 128;
    localparam int NBYTES = BLK_W / 8;
    localparam int COL_W  = 32;
    localparam int NCOLS  = BLK_W / COL_W;
    localparam int IDX_W  = 4;

    typedef logic [BLK_W-1:0] block_t;
    typedef logic [7:0]       byte_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        KS_128 = 2'b00,
        KS_192 = 2'b01,
        KS_256 = 2'b10,
        KS_ALT = 2'b11
    } key_size_e;

    // control strobes handed from the sequencer to the datapath
    typedef struct packed {
        logic go;    // accept a new block this edge
        logic step;  // perform one inverse round this edge
        logic last;  // the round performed is the final one
    } seq_t;

    function automatic idx_t nr_of(input logic [1:0] ks);
        case (key_size_e'(ks))
            KS_192:  nr_of = idx_t'(12);
            KS_256:  nr_of = idx_t'(14);
            default: nr_of = idx_t'(10);
        endcase
    endfunction

    function automatic byte_t xt(input byte_t b);
        xt = {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t p;
        byte_t aa;
        p  = 8'h00;
        aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = xt(aa);
        end
        gmul = p;
    endfunction

    // multiplicative inverse as a^254 (maps 0 to 0)
    function automatic byte_t ginv(input byte_t a);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gmul(r, p);
            p = gmul(p, p);
        end
        ginv = r;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        rotl8 = byte_t'((a << n) | (a >> (8 - n)));
    endfunction

    function automatic byte_t inv_sbox(input byte_t a);
        byte_t b;
        b = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
        inv_sbox = ginv(b);
    endfunction

    function automatic logic [COL_W-1:0] imix_col(input logic [COL_W-1:0] c);
        byte_t a0, a1, a2, a3;
        a0 = c[31:24];
        a1 = c[23:16];
        a2 = c[15:8];
        a3 = c[7:0];
        imix_col = {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
                    gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
                    gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
                    gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
    endfunction

endpackage

// File: rtl/aes_inv_round.sv
module aes_inv_round
    import aes_inv_pkg::*;
(
    input  block_t st_in,
    input  block_t rk,
    input  logic   last,
    output block_t st_out
);

    block_t sub;
    block_t ark;
    block_t mix;

    // InvShiftRows folded into the InvSubBytes wiring: row r moves right by r
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int DST = r + 4 * c;
            localparam int SRC = r + 4 * ((c - r + 4) % 4);
            assign sub[BLK_W-1-8*DST -: 8] = inv_sbox(st_in[BLK_W-1-8*SRC -: 8]);
        end
    end

    assign ark = sub ^ rk;

    for (genvar c = 0; c < NCOLS; c++) begin : g_mix
        assign mix[BLK_W-1-COL_W*c -: COL_W] = imix_col(ark[BLK_W-1-COL_W*c -: COL_W]);
    end

    assign st_out = last ? ark : mix;

endmodule

// File: rtl/aes_inv_seq.sv
module aes_inv_seq
    import aes_inv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] key_size,
    output seq_t       ctl,
    output idx_t       rk_idx
);

    idx_t left;     // rounds still to perform
    idx_t nr_now;
    logic idle;

    assign nr_now = nr_of(key_size);
    assign idle   = (left == '0);

    always_comb begin
        ctl.go   = start && idle;
        ctl.step = !idle;
        ctl.last = (left == idx_t'(1));
    end

    // index leads consumption by one cycle
    always_comb begin
        if (left >= idx_t'(2))
            rk_idx = left - idx_t'(2);
        else if (ctl.go)
            rk_idx = nr_now - idx_t'(1);
        else
            rk_idx = nr_now;
    end

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (ctl.go)
            left <= nr_now;
        else if (!idle)
            left <= left - idx_t'(1);
    end

endmodule

// File: rtl/aes_block_decrypt.sv
module aes_block_decrypt
    import aes_inv_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   key_size,
    input  logic [127:0] ct_in,
    input  logic [127:0] rk_word,
    output logic [3:0]   rk_idx,
    output logic [127:0] pt_out,
    output logic         pt_ready
);

    seq_t   ctl;
    block_t st;
    block_t nxt;

    aes_inv_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .key_size (key_size),
        .ctl      (ctl),
        .rk_idx   (rk_idx)
    );

    aes_inv_round u_round (
        .st_in  (st),
        .rk     (rk_word),
        .last   (ctl.last),
        .st_out (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            pt_out   <= '0;
            pt_ready <= 1'b0;
        end else begin
            pt_ready <= 1'b0;
            if (ctl.go) begin
                st <= ct_in ^ rk_word;
            end else if (ctl.step) begin
                st <= nxt;
                if (ctl.last) begin
                    pt_out   <= nxt;
                    pt_ready <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/aes_block_decrypt_chk.sv
module aes_block_decrypt_chk
    import aes_inv_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [1:0]   key_size,
    input logic [3:0]   rk_idx,
    input logic [127:0] pt_out,
    input logic         pt_ready
);

    logic       chk_busy;
    logic [4:0] cnt;
    logic [4:0] nr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_busy <= 1'b0;
            cnt      <= '0;
            nr_q     <= '0;
        end else if (chk_busy) begin
            if (cnt == nr_q) chk_busy <= 1'b0;
            else             cnt <= cnt + 5'd1;
        end else if (start) begin
            chk_busy <= 1'b1;
            cnt      <= 5'd1;
            nr_q     <= {1'b0, nr_of(key_size)};
        end
    end

    // R4: the pulse follows the Nr-th edge after acceptance, and only then
    a_r4_ready_when_due: assert property (@(posedge clk) disable iff (rst)
        pt_ready |-> $past(chk_busy && (cnt == nr_q)));

    a_r4_ready_arrives: assert property (@(posedge clk) disable iff (rst)
        (chk_busy && (cnt == nr_q)) |=> pt_ready);

    // R8: output register moves only with the completion pulse
    a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
        !pt_ready |-> $stable(pt_out));

    // R2 and R5: idle value, and the value in the final round cycle
    a_r2_idle_index: assert property (@(posedge clk) disable iff (rst)
        ((!chk_busy && !start) || (chk_busy && (cnt == nr_q)))
        |-> ({1'b0, rk_idx} == {1'b0, nr_of(key_size)}));

    // R3: the start cycle asks for key Nr-1
    a_r3_start_index: assert property (@(posedge clk) disable iff (rst)
        (!chk_busy && start) |-> ({1'b0, rk_idx} == {1'b0, nr_of(key_size)} - 5'd1));

    // R5: countdown while rounds remain
    a_r5_index_countdown: assert property (@(posedge clk) disable iff (rst)
        (chk_busy && (cnt < nr_q)) |-> ({1'b0, rk_idx} == nr_q - cnt - 5'd1));

endmodule

bind aes_block_decrypt aes_block_decrypt_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .key_size (key_size),
    .rk_idx   (rk_idx),
    .pt_out   (pt_out),
    .pt_ready (pt_ready)
);

// File: tb/aes_block_decrypt_bench.sv
module aes_block_decrypt_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   key_size = 2'b00;
    logic [127:0] ct_in = '0;
    logic [127:0] rk_word = '0;
    logic [3:0]   rk_idx;
    logic [127:0] pt_out;
    logic         pt_ready;

    aes_block_decrypt u_aes_block_decrypt (
        .clk(clk), .rst(rst), .start(start), .key_size(key_size),
        .ct_in(ct_in), .rk_word(rk_word), .rk_idx(rk_idx),
        .pt_out(pt_out), .pt_ready(pt_ready)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [7:0]   sb [256];
    logic [127:0] sched [15];
    logic [127:0] drv_plain = '0;

    localparam logic [127:0] PLAIN = 128'h00112233445566778899aabbccddeeff;

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural AES forward side ----------------
    function automatic logic [7:0] dbl(input logic [7:0] b);
        dbl = b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
    endfunction

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        for (int i = 7; i >= 0; i--) p = dbl(p) ^ (b[i] ? a : 8'h00);
        gm = p;
    endfunction

    function automatic logic [7:0] rl(input logic [7:0] a, input int n);
        rl = (a << n) | (a >> (8 - n));
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            for (int y = 1; y < 256; y++)
                if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sb[x] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
        end
    endtask

    function automatic logic [31:0] subw(input logic [31:0] w);
        subw = {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    function automatic int nr_ref(input logic [1:0] ks);
        nr_ref = (ks == 2'b01) ? 12 : (ks == 2'b10) ? 14 : 10;
    endfunction

    task automatic key_expand(input logic [255:0] key, input int nk, input int nr);
        logic [31:0] w [60];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
        for (int i = nk; i < 4 * (nr + 1); i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t  = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = dbl(rc);
            end else if (nk > 6 && i % nk == 4) begin
                t = subw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int j = 0; j < 15; j++)
            sched[j] = (j <= nr) ? {w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]} : '0;
    endtask

    function automatic logic [127:0] encrypt(input logic [127:0] blk, input int nr);
        logic [127:0] s, o;
        s = blk ^ sched[0];
        for (int rnd = 1; rnd <= nr; rnd++) begin
            for (int i = 0; i < 16; i++) s[127-8*i -: 8] = sb[s[127-8*i -: 8]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    o[127-8*(r+4*c) -: 8] = s[127-8*(r+4*((c+r)%4)) -: 8];
            s = o;
            if (rnd != nr) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0, a1, a2, a3;
                    a0 = s[127-32*c -: 8]; a1 = s[119-32*c -: 8];
                    a2 = s[111-32*c -: 8]; a3 = s[103-32*c -: 8];
                    s[127-32*c -: 32] = {gm(a0,2)^gm(a1,3)^a2^a3, a0^gm(a1,2)^gm(a2,3)^a3,
                                         a0^a1^gm(a2,2)^gm(a3,3), gm(a0,3)^a1^a2^gm(a3,2)};
                end
            end
            s = s ^ sched[rnd];
        end
        encrypt = s;
    endfunction

    // ---------------- key store: synchronous read ----------------
    always @(posedge clk) rk_word <= sched[rk_idx];

    // ---------------- cycle reference model ----------------
    bit           mbusy = 0;
    int           mcnt = 0, mnr = 10;
    logic [127:0] mpend = '0, e_pt = '0;
    bit           e_rdy = 0;

    always @(posedge clk) begin
        if (rst) begin
            mbusy = 0; mcnt = 0; e_rdy = 0; e_pt = '0;
        end else begin
            e_rdy = 0;
            if (mbusy) begin
                mcnt++;
                if (mcnt == mnr) begin
                    e_rdy = 1; e_pt = mpend; mbusy = 0;
                end
            end else if (start) begin
                mbusy = 1; mcnt = 0; mnr = nr_ref(key_size); mpend = drv_plain;
            end
        end
    end

    always @(posedge clk) begin
        int ei, r;
        #6;
        cyc++;
        if (mbusy) begin
            r  = mnr - mcnt;
            ei = (r >= 2) ? r - 2 : nr_ref(key_size);
        end else begin
            ei = start ? nr_ref(key_size) - 1 : nr_ref(key_size);
        end
        if (rst) begin
            check(pt_ready == 1'b0, "R1 ready in reset", 128'(pt_ready), 0);
            check(pt_out == '0, "R1 output in reset", pt_out, 0);
        end else begin
            check(int'(rk_idx) == ei, mbusy ? "R5 index" : (start ? "R3 index" : "R2 index"),
                  128'(rk_idx), 128'(ei));
            check(pt_ready == e_rdy, "R4 ready timing", 128'(pt_ready), 128'(e_rdy));
            check(pt_out == e_pt, e_rdy ? "R4 result" : "R8 hold", pt_out, e_pt);
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL R4 watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_key(input logic [255:0] key, input int nk, input logic [1:0] ks);
        key_expand(key, nk, nr_ref(ks));
        key_size = ks;
        repeat (3) tick();
    endtask

    task automatic start_block(input logic [127:0] c, input logic [127:0] p);
        start = 1; ct_in = c; drv_plain = p;
        tick();
        start = 0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!pt_ready && n < 40);
    endtask

    function automatic logic [127:0] rnd128();
        rnd128 = {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic kat(input logic [255:0] key, input int nk, input logic [1:0] ks,
                       input logic [127:0] c, input string tag);
        int n;
        set_key(key, nk, ks);
        check(encrypt(PLAIN, nr_ref(ks)) == c, "R4 reference vector", encrypt(PLAIN, nr_ref(ks)), c);
        start_block(c, PLAIN);
        wait_ready(n);
        check(n == nr_ref(ks), {tag, " R4 latency"}, 128'(n), 128'(nr_ref(ks)));
        check(pt_out == PLAIN, {tag, " R3/R4 plaintext"}, pt_out, PLAIN);
    endtask

    initial begin
        int n, tot;
        logic [127:0] p [3];
        logic [127:0] c [3];
        logic [127:0] hold;
        logic [255:0] k;

        build_sbox();
        key_expand({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 4, 10);
        repeat (5) tick();
        rst = 0;
        tick();
        check(pt_ready == 1'b0, "R1 ready after reset", 128'(pt_ready), 0);
        check(pt_out == '0, "R1 output after reset", pt_out, 0);
        check(rk_idx == 4'd10, "R1 idle index", 128'(rk_idx), 10);

        kat({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 4, 2'b00,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "k128");
        kat({192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0}, 6, 2'b01,
            128'hdda97ca4864cdfe06eaf70a0ec0d7191, "k192");
        kat(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 8, 2'b10,
            128'h8ea2b7ca516745bfeafc49904b496089, "k256");
        kat({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 4, 2'b11,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 alias");

        // R6: start raised in the final round cycle is ignored
        set_key({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 4, 2'b00);
        start_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, PLAIN);
        repeat (9) tick();
        start = 1; ct_in = rnd128(); drv_plain = rnd128();
        tick();
        start = 0;
        check(pt_ready == 1'b1, "R6 ready after final-cycle start", 128'(pt_ready), 1);
        check(pt_out == PLAIN, "R6 result after final-cycle start", pt_out, PLAIN);
        repeat (14) tick();
        check(pt_ready == 1'b0, "R6 no phantom block", 128'(pt_ready), 0);

        // R7: back-to-back with a random 192-bit key
        k = {rnd128(), rnd128()};
        set_key(k, 6, 2'b01);
        for (int i = 0; i < 3; i++) begin
            p[i] = rnd128();
            c[i] = encrypt(p[i], 12);
        end
        start_block(c[0], p[0]);
        wait_ready(n);
        check(pt_out == p[0], "R7 first block", pt_out, p[0]);
        for (int i = 1; i < 3; i++) begin
            start_block(c[i], p[i]);
            wait_ready(n);
            check(n == 12, "R7 back-to-back spacing", 128'(n + 1), 128'(13));
            check(pt_out == p[i], "R7 streamed block", pt_out, p[i]);
        end

        // R9 and R6: 256-bit random key, disturbances while busy
        k = {rnd128(), rnd128()};
        set_key(k, 8, 2'b10);
        p[0] = rnd128();
        c[0] = encrypt(p[0], 14);
        start_block(c[0], p[0]);
        repeat (2) tick();
        start = 1; ct_in = rnd128(); drv_plain = rnd128();
        tick();
        start = 0; key_size = 2'b00; ct_in = rnd128();
        repeat (3) tick();
        key_size = 2'b10;
        wait_ready(n);
        tot = 6 + n;
        check(tot == 14, "R9 round count kept", 128'(tot), 128'(14));
        check(pt_out == p[0], "R9/R6 result kept", pt_out, p[0]);

        // R8: output holds while inputs wander
        hold = pt_out;
        for (int i = 0; i < 20; i++) begin
            ct_in = rnd128();
            tick();
        end
        check(pt_out == hold, "R8 output held", pt_out, hold);
        check(pt_ready == 1'b0, "R8 no pulse while idle", 128'(pt_ready), 0);

        tick();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule